// File: doc/BRIEF.md
# Byte DMA Channel Controller with Pause and Discard

This block sequences a byte-wide receive DMA channel under level commands from a local controller. A read command opens the channel. A pause command holds it. An abort command tears the channel down and acknowledges its interrupt. A discard mode lets the channel keep consuming bytes without storing them and without ending the transfer. Bytes arrive on a valid/ready strobe, and each one carries an end-of-message (EOI) bit. Stored bytes leave one cycle later on a write strobe toward memory. Bus handshaking and address generation belong to the surrounding logic.

The channel keeps three status bits. The odd flag shows the parity of the number of stored bytes. The last-EOI bit holds the EOI marker of the newest stored byte. The interrupt is raised by device end, which happens in two ways. The first is an EOI byte. The second is the end of a loaded byte count while end-on-count is enabled. After device end, the channel stays done until the read command is dropped. Withdrawing read or asserting pause never loses a byte: a byte accepted in the same cycle is still stored.

Top module: `dma_chan_ctl`

## Requirements
- R1: While reset (rstN low) is applied and after its release, byteReady, memWrite, oddFlag, lastEoi, dmaIrq and xferDone are all 0.
- R2: From idle, a high cmdRead starts the channel. byteReady rises in the cycle after the starting edge, or stays low if cmdPause is high. Starting clears oddFlag.
- R3: When cmdRead goes low, a byte offered and accepted in that same cycle is still stored. From the next cycle on, byteReady is 0.
- R4: While cmdPause is high, byteReady is 0 from the cycle after it rises. No byte is taken. Clearing cmdPause resumes acceptance.
- R5: cmdAbort forces byteReady to 0 in the same cycle, so a byte offered then is not taken. After the edge, the channel is idle and both dmaIrq and oddFlag are 0.
- R6: With cmdBucket high, an accepted byte produces no memWrite. It leaves oddFlag, lastEoi, the byte count and dmaIrq unchanged, and it never ends the transfer, even when its EOI bit is 1.
- R7: oddFlag toggles on every stored byte, so it is 1 after the 1st, 3rd, 5th… byte since the start.
- R8: lastEoi equals the byteEoi value of the most recently stored byte.
- R9: With cmdEocEn high, storing a byte while the loaded count is 1 ends the transfer: xferDone=1, byteReady=0 and dmaIrq=1. Each stored byte decrements a nonzero count. A count of 0, or cmdEocEn low, never ends a transfer.
- R10: Storing a byte with byteEoi=1 ends the transfer and sets dmaIrq. dmaIrq then stays 1 until cmdAbort.
- R11: After device end, xferDone stays 1 and byteReady stays 0 until cmdRead goes low. The channel then returns to idle and can be started again.
- R12: Every stored byte appears on memData with memWrite high in the cycle after acceptance, in acceptance order, and no other memWrite pulses occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdRead | input | 1 | Level: run a receive transfer |
| cmdPause | input | 1 | Level: hold the transfer |
| cmdAbort | input | 1 | Abort the transfer and clear the interrupt |
| cmdBucket | input | 1 | Level: discard accepted bytes |
| cmdEocEn | input | 1 | Level: end the transfer when the count runs out |
| cntLoad | input | 1 | Load strobe for the byte count |
| cntValue | input | CNT_W | Byte count to load |
| byteValid | input | 1 | A byte is offered |
| byteData | input | DATA_W | Offered byte |
| byteEoi | input | 1 | EOI marker of the offered byte |
| byteReady | output | 1 | Channel accepts the offered byte this cycle |
| memWrite | output | 1 | Stored byte valid toward memory |
| memData | output | DATA_W | Stored byte |
| oddFlag | output | 1 | Odd number of bytes stored since start |
| lastEoi | output | 1 | EOI marker of the newest stored byte |
| dmaIrq | output | 1 | Device-end interrupt |
| xferDone | output | 1 | Transfer ended by device end |

## Verification
Two functions can fall in the same cycle: a byte being accepted and a command that stops the channel. The bench provokes this by dropping cmdRead in the very cycle a byte is offered, and it requires that byte to come out on memWrite while byteReady falls in the following cycle. In the opposite case, an abort coincides with an offered byte. There the byte must never reach memory, and the scoreboard flags any unexpected write. Both the pause case and the end-of-count case are judged the same way: the expected-byte queue must drain exactly.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } chanState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic take;    // byte stored (accepted and not discarded)
    logic start;   // channel opened from idle
    logic abort;   // channel torn down
    logic raise;   // device end reached by this byte
  } chanStb_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdRead,
  input  logic     cmdPause,
  input  logic     cmdAbort,
  input  logic     cmdBucket,
  input  logic     cmdEocEn,
  input  logic     byteValid,
  input  logic     byteEoi,
  input  logic     lastCount,
  output logic     byteReady,
  output logic     xferDone,
  output chanStb_t stb
);
  chanState_t state, stateNext;
  logic accept, endByte;

  assign byteReady = (state == ST_RUN) && !cmdAbort;
  assign accept    = byteValid && byteReady;
  assign endByte   = stb.take && (byteEoi || (cmdEocEn && lastCount));
  assign xferDone  = (state == ST_DONE);

  always_comb begin
    stb.take  = accept && !cmdBucket;
    stb.start = (state == ST_IDLE) && cmdRead && !cmdAbort;
    stb.abort = cmdAbort;
    stb.raise = 1'b0;
    stb.raise = endByte;
  end

  always_comb begin
    stateNext = state;
    if (cmdAbort) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (cmdRead) stateNext = cmdPause ? ST_HOLD : ST_RUN;
        ST_RUN: begin
          if (endByte)       stateNext = ST_DONE;
          else if (!cmdRead) stateNext = ST_IDLE;
          else if (cmdPause) stateNext = ST_HOLD;
        end
        ST_HOLD: begin
          if (!cmdRead)      stateNext = ST_IDLE;
          else if (!cmdPause) stateNext = ST_RUN;
        end
        ST_DONE: if (!cmdRead) stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dma_chan_path.sv
module dma_chan_path
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic              cntLoad,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteEoi,
  output logic              lastCount,
  output logic              memWrite,
  output logic [DATA_W-1:0] memData,
  output logic              oddFlag,
  output logic              lastEoi,
  output logic              dmaIrq
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] count;

  assign lastCount = (count == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= CNT_ZERO;
      memWrite <= 1'b0;
      memData  <= '0;
      oddFlag  <= 1'b0;
      lastEoi  <= 1'b0;
      dmaIrq   <= 1'b0;
    end else begin
      memWrite <= stb.take;
      if (stb.take) begin
        memData <= byteData;
        lastEoi <= byteEoi;
      end
      if (cntLoad)                           count <= cntValue;
      else if (stb.take && count != CNT_ZERO) count <= count - CNT_ONE;
      if (stb.abort || stb.start) oddFlag <= 1'b0;
      else if (stb.take)          oddFlag <= ~oddFlag;
      if (stb.abort)      dmaIrq <= 1'b0;
      else if (stb.raise) dmaIrq <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdRead,
  input  logic              cmdPause,
  input  logic              cmdAbort,
  input  logic              cmdBucket,
  input  logic              cmdEocEn,
  input  logic              cntLoad,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteEoi,
  output logic              byteReady,
  output logic              memWrite,
  output logic [DATA_W-1:0] memData,
  output logic              oddFlag,
  output logic              lastEoi,
  output logic              dmaIrq,
  output logic              xferDone
);
  chanStb_t stb;
  logic     lastCount;

  dma_chan_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdRead(cmdRead), .cmdPause(cmdPause), .cmdAbort(cmdAbort),
    .cmdBucket(cmdBucket), .cmdEocEn(cmdEocEn),
    .byteValid(byteValid), .byteEoi(byteEoi), .lastCount(lastCount),
    .byteReady(byteReady), .xferDone(xferDone), .stb(stb)
  );

  dma_chan_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) path_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cntLoad(cntLoad), .cntValue(cntValue),
    .byteData(byteData), .byteEoi(byteEoi),
    .lastCount(lastCount),
    .memWrite(memWrite), .memData(memData),
    .oddFlag(oddFlag), .lastEoi(lastEoi), .dmaIrq(dmaIrq)
  );
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdRead,
  input logic              cmdPause,
  input logic              cmdAbort,
  input logic              cmdBucket,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteData,
  input logic              byteReady,
  input logic              memWrite,
  input logic [DATA_W-1:0] memData,
  input logic              oddFlag,
  input logic              dmaIrq
);
  // R5
  abort_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdAbort |-> !byteReady);

  // R5
  abort_clears_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdAbort |=> (!dmaIrq && !oddFlag && !byteReady));

  // R3
  read_drop_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRead |=> !byteReady);

  // R4
  pause_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdPause |=> !byteReady);

  // R12
  stored_byte_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteReady && !cmdBucket) |=> (memWrite && memData == $past(byteData)));

  // R6
  bucket_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteReady && cmdBucket) |=> (!memWrite && $stable(oddFlag)));

  // R7
  odd_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteReady && !cmdBucket) |=> (oddFlag != $past(oddFlag)));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaIrq && !cmdAbort) |=> dmaIrq);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  localparam int  DATA_W = 8;
  localparam int  CNT_W  = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN;
  logic cmdRead, cmdPause, cmdAbort, cmdBucket, cmdEocEn, cntLoad;
  logic [CNT_W-1:0]  cntValue;
  logic byteValid, byteEoi;
  logic [DATA_W-1:0] byteData;
  logic byteReady, memWrite, oddFlag, lastEoi, dmaIrq, xferDone;
  logic [DATA_W-1:0] memData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [DATA_W-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdRead(cmdRead), .cmdPause(cmdPause), .cmdAbort(cmdAbort),
    .cmdBucket(cmdBucket), .cmdEocEn(cmdEocEn),
    .cntLoad(cntLoad), .cntValue(cntValue),
    .byteValid(byteValid), .byteData(byteData), .byteEoi(byteEoi),
    .byteReady(byteReady), .memWrite(memWrite), .memData(memData),
    .oddFlag(oddFlag), .lastEoi(lastEoi), .dmaIrq(dmaIrq), .xferDone(xferDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offer one byte, wait for acceptance, record expected store
  task automatic offer(input logic [DATA_W-1:0] d, input logic e);
    bit got = 0;
    @(negedge clk);
    byteData = d; byteEoi = e; byteValid = 1'b1;
    for (int w = 0; w < 20 && !got; w++) begin
      #1;
      got = byteReady;
      if (got && !cmdBucket) expQ.push_back(d);
      @(negedge clk);
    end
    byteValid = 1'b0;
    check("R12 byte accepted", int'(got), 1);
  endtask

  // monitor: compare stored bytes against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rstN === 1'b1 && memWrite === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected write actual=%0d expected=none", memData);
      end else begin
        logic [DATA_W-1:0] e;
        e = expQ.pop_front();
        if (memData !== e) begin
          failures++;
          $display("FAIL R12 stored byte actual=%0d expected=%0d", memData, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rstN = 0; cmdRead = 0; cmdPause = 0; cmdAbort = 0; cmdBucket = 0;
    cmdEocEn = 0; cntLoad = 0; cntValue = '0;
    byteValid = 0; byteData = '0; byteEoi = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready in reset", int'(byteReady), 0);
    rstN = 1;
    @(negedge clk); #1;
    check("R1 ready", int'(byteReady), 0);
    check("R1 write", int'(memWrite), 0);
    check("R1 odd", int'(oddFlag), 0);
    check("R1 lastEoi", int'(lastEoi), 0);
    check("R1 irq", int'(dmaIrq), 0);
    check("R1 done", int'(xferDone), 0);

    // R2 start
    cmdRead = 1;
    @(negedge clk); #1;
    check("R2 ready after start", int'(byteReady), 1);

    // R7 odd flag over three bytes
    offer(8'h11, 0); #1; check("R7 odd after 1", int'(oddFlag), 1);
    offer(8'h22, 0); #1; check("R7 odd after 2", int'(oddFlag), 0);
    offer(8'h33, 0); #1; check("R7 odd after 3", int'(oddFlag), 1);
    check("R8 lastEoi clear", int'(lastEoi), 0);

    // R4 pause with a byte waiting
    @(negedge clk); cmdPause = 1;
    fork
      offer(8'h44, 0);
      begin
        repeat (3) @(negedge clk);
        #1; check("R4 ready while paused", int'(byteReady), 0);
        check("R4 no write while paused", int'(memWrite), 0);
        @(negedge clk); cmdPause = 0;
      end
    join
    #1; check("R4 resumed odd", int'(oddFlag), 0);

    // R3 read drop in the same cycle as a byte
    @(negedge clk);
    byteValid = 1; byteData = 8'h55; byteEoi = 0; cmdRead = 0;
    #1;
    check("R3 byte taken at drop", int'(byteReady), 1);
    if (byteReady) expQ.push_back(8'h55);
    @(negedge clk); byteValid = 0; #1;
    check("R3 ready after drop", int'(byteReady), 0);
    check("R3 stored byte", int'(memWrite), 1);
    check("R7 odd after 5", int'(oddFlag), 1);

    // R2 restart clears odd
    @(negedge clk); cmdRead = 1;
    @(negedge clk); #1;
    check("R2 odd cleared by start", int'(oddFlag), 0);
    check("R2 ready after restart", int'(byteReady), 1);

    // R6 bucket mode with EOI byte
    cmdBucket = 1;
    offer(8'h66, 1); #1;
    check("R6 odd unchanged", int'(oddFlag), 0);
    check("R6 lastEoi unchanged", int'(lastEoi), 0);
    check("R6 irq unchanged", int'(dmaIrq), 0);
    check("R6 not ended", int'(byteReady), 1);
    check("R6 no write", int'(memWrite), 0);
    cmdBucket = 0;

    // R10 / R8 EOI byte ends transfer
    offer(8'h77, 1); #1;
    check("R8 lastEoi set", int'(lastEoi), 1);
    check("R10 irq set", int'(dmaIrq), 1);
    check("R10 done", int'(xferDone), 1);
    check("R10 ready low", int'(byteReady), 0);

    // R11 done held until read drops
    repeat (3) @(negedge clk); #1;
    check("R11 done held", int'(xferDone), 1);
    check("R10 irq held", int'(dmaIrq), 1);
    cmdRead = 0;
    @(negedge clk); #1;
    check("R11 idle after drop", int'(xferDone), 0);
    check("R10 irq kept after idle", int'(dmaIrq), 1);

    // R5 abort with a byte offered
    cmdRead = 1;
    offer(8'h88, 0); #1;
    check("R5 odd before abort", int'(oddFlag), 1);
    @(negedge clk);
    cmdAbort = 1; byteValid = 1; byteData = 8'h99; byteEoi = 0;
    #1; check("R5 ready during abort", int'(byteReady), 0);
    @(negedge clk); cmdAbort = 0; byteValid = 0; #1;
    check("R5 irq cleared", int'(dmaIrq), 0);
    check("R5 odd cleared", int'(oddFlag), 0);
    check("R5 idle", int'(byteReady), 0);
    check("R5 no write", int'(memWrite), 0);

    // R9 end on count
    cntLoad = 1; cntValue = 16'd2; cmdEocEn = 1;
    @(negedge clk); cntLoad = 0;
    offer(8'hA1, 0); #1;
    check("R9 not ended at count 2", int'(xferDone), 0);
    offer(8'hA2, 0); #1;
    check("R9 ended at count", int'(xferDone), 1);
    check("R9 irq at count", int'(dmaIrq), 1);
    check("R9 ready low", int'(byteReady), 0);
    check("R8 lastEoi follows newest", int'(lastEoi), 0);

    // R9 count disabled: no termination
    cmdRead = 0; cmdAbort = 1;
    @(negedge clk); cmdAbort = 0; cmdEocEn = 0; cntLoad = 1; cntValue = 16'd1;
    @(negedge clk); cntLoad = 0; cmdRead = 1;
    offer(8'hB1, 0); #1;
    check("R9 disabled no end", int'(xferDone), 0);
    check("R9 disabled ready", int'(byteReady), 1);
    check("R9 disabled irq", int'(dmaIrq), 0);

    cmdRead = 0;
    repeat (3) @(negedge clk); #3;
    check("R12 queue drained", expQ.size(), 0);
    finish_run();
  end
endmodule